// File: doc/BRIEF.md
# HyperBus DDR Memory Controller

This block is the host side of a HyperBus pseudo-static RAM built from two stacked dies. A user-side request names a direction, a space (memory array or configuration registers), a burst type, a 32-bit address and a byte count. The controller then runs one framed transaction on the memory pins. It lowers chip select and sends a 48-bit command/address word as six bytes on the shared 8-bit bus. For array accesses it then waits a fixed initial latency, which is always the doubled value. Finally it moves the burst data and raises chip select again.

The core runs on a system clock at twice the bus clock rate. Each system cycle carries one byte, so the bus clock output toggles every cycle and two bytes pass per bus clock. Write bytes are pulled from the user one per cycle, and each carries a mask bit that is driven on the strobe pin. Read bytes are taken only when the memory's strobe changes level. Configuration writes skip the latency and carry exactly two bytes. Address bit 22 travels as command bit 35 and picks which die receives them. Because of this, each die is set up, or sent into deep power-down, by its own register write.

Top module: `hbus_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, cs_n is 1, ck_o is 0, dq_oe and rwds_oe are 0 and req_ready is 1. A reset during a transaction abandons it.
- R2: After a request is accepted, cs_n falls in the next cycle. Six command/address bytes follow on dq_o, most significant first, with dq_oe high. The 48-bit word is: bit 47 = 1 for read, bit 46 = register space, bit 45 = linear burst, bits 44:16 = req_addr[31:3], bits 15:3 = 0, bits 2:0 = req_addr[2:0].
- R3: ck_o is 0 in the first cycle with cs_n low and inverts every cycle while cs_n stays low. It is 0 whenever cs_n is high.
- R4: For array accesses the data phase begins exactly 6 + 4*LATENCY cycles after cs_n falls. The rwds_i level during the command phase has no effect on this.
- R5: In an array write, wr_take is high for req_len consecutive cycles. In each of those cycles dq_o equals wr_data and rwds_o equals wr_mask (1 = byte not written), with rwds_oe high.
- R6: A register write carries exactly two data bytes in cycles 6 and 7 after cs_n falls, whatever req_len is. rwds_oe stays 0.
- R7: In a read, a byte is taken from dq_i only at a clock where rwds_i differs from its value at the previous clock. It appears on rd_data with rd_valid one cycle later, in order. Cycles without a strobe change extend the frame and deliver nothing.
- R8: After the last data byte, cs_n is high with dq_oe and rwds_oe low for GAP_CYC (2) cycles. done_o pulses in the first of them. req_ready is 1 only when idle.
- R9: Command bit 35 (second command byte, bit 3) equals req_addr[22]. A register write therefore reaches die 0 or die 1 alone, which covers a deep power-down request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = configuration register space |
| req_linear | input | 1 | 1 = linear burst, 0 = wrapped |
| req_addr | input | 32 | Request address; bit 22 selects the die |
| req_len | input | LEN_W | Data bytes for array accesses |
| wr_data | input | 8 | Write byte for the current data cycle |
| wr_mask | input | 1 | Mask bit for the current write byte |
| wr_take | output | 1 | wr_data/wr_mask consumed this cycle |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | rd_data valid |
| done_o | output | 1 | Transaction finished |
| cs_n | output | 1 | Chip select, low during a frame |
| ck_o | output | 1 | Single-ended bus clock |
| dq_o | output | 8 | Bus data out |
| dq_oe | output | 1 | Bus data output enable |
| dq_i | input | 8 | Bus data in |
| rwds_o | output | 1 | Strobe/mask out |
| rwds_oe | output | 1 | Strobe/mask output enable |
| rwds_i | input | 1 | Strobe in |

## Verification
Every result is tied to a cycle index k that counts from the first cycle with cs_n low. Command bytes and the ck_o level are due in cycles 0 to 5. The first write byte is due at cycle 6 + 4*LATENCY, or at cycle 6 for register writes. done_o is due in the first cycle after the frame, and req_ready two cycles after that. A read byte taken at the end of cycle k is due on rd_data in cycle k+1. The bench keeps this schedule by sampling every output at the falling clock edge and indexing each expectation by k. It drives dq_i and rwds_i at that same edge, so each strobe change lands one full half-period before the capturing edge.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int CA_BYTES = 6;
    localparam int CA_W     = 8 * CA_BYTES;
    localparam int ADDR_W   = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CA,
        ST_LAT,
        ST_DATA,
        ST_GAP
    } hb_state_e;

    typedef struct packed {
        logic              write;
        logic              regsp;
        logic              linear;
        logic [ADDR_W-1:0] addr;
    } hb_cmd_t;

    // 48-bit command word; bit 35 carries addr[22] (die select)
    function automatic logic [CA_W-1:0] hb_make_ca(hb_cmd_t c);
        return {~c.write, c.regsp, c.linear, c.addr[31:3], 13'd0, c.addr[2:0]};
    endfunction

    function automatic logic [7:0] hb_ca_byte(logic [CA_W-1:0] ca, logic [2:0] idx);
        logic [7:0] b;
        b = 8'h00;
        for (int i = 0; i < CA_BYTES; i++) begin
            if (idx == 3'(i)) b = ca[8*(CA_BYTES-1-i) +: 8];
        end
        return b;
    endfunction

endpackage

// File: rtl/hbus_fsm.sv
module hbus_fsm
    import hbus_pkg::*;
#(
    parameter int LAT_CYC = 24,
    parameter int GAP_CYC = 2,
    parameter int LEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_write,
    input  logic             skip_lat,
    input  logic [LEN_W-1:0] len,
    input  logic             rd_step,
    output hb_state_e        state,
    output logic [2:0]       ca_idx,
    output logic             first_gap
);

    localparam int CNT_W = $clog2(LAT_CYC + (1 << LEN_W) + GAP_CYC + CA_BYTES);
    localparam logic [CNT_W-1:0] CA_LAST  = CNT_W'(CA_BYTES - 1);
    localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(LAT_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] data_last;
    logic             data_step;

    assign data_last = CNT_W'(len) - 1'b1;
    assign data_step = is_write || rd_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_CA;
                        cnt   <= '0;
                    end
                end
                ST_CA: begin
                    if (cnt == CA_LAST) begin
                        cnt   <= '0;
                        state <= skip_lat ? ST_DATA : ST_LAT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LAT: begin
                    if (cnt == LAT_LAST) begin
                        cnt   <= '0;
                        state <= ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (data_step) begin
                        if (cnt == data_last) begin
                            cnt   <= '0;
                            state <= ST_GAP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt == GAP_LAST) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign ca_idx    = cnt[2:0];
    assign first_gap = (state == ST_GAP) && (cnt == '0);

endmodule

// File: rtl/hbus_ckgen.sv
module hbus_ckgen (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ck_o
);

    logic ck_q;

    always_ff @(posedge clk) begin
        if (rst || !run) ck_q <= 1'b0;
        else             ck_q <= ~ck_q;
    end

    assign ck_o = ck_q & run;

endmodule

// File: rtl/hbus_rd_capture.sv
module hbus_rd_capture (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       rwds_i,
    input  logic [7:0] dq_i,
    output logic       byte_ok,
    output logic [7:0] rd_data,
    output logic       rd_valid
);

    logic rwds_q;

    assign byte_ok = arm && (rwds_i != rwds_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rwds_q   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rwds_q   <= rwds_i;
            rd_valid <= byte_ok;
            if (byte_ok) rd_data <= dq_i;
        end
    end

endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int LATENCY = 6,
    parameter int GAP_CYC = 2,
    parameter int LEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_reg,
    input  logic             req_linear,
    input  logic [31:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_mask,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done_o,
    output logic             cs_n,
    output logic             ck_o,
    output logic [7:0]       dq_o,
    output logic             dq_oe,
    input  logic [7:0]       dq_i,
    output logic             rwds_o,
    output logic             rwds_oe,
    input  logic             rwds_i
);

    // fixed latency: doubled, two system cycles per bus clock
    localparam int LAT_CYC = 4 * LATENCY;
    localparam logic [LEN_W-1:0] REG_LEN = LEN_W'(2);

    hb_cmd_t          cmd_q;
    logic [LEN_W-1:0] len_q;
    hb_state_e        state;
    logic [2:0]       ca_idx;
    logic             first_gap;
    logic             start;
    logic             rd_step;
    logic             in_frame;
    logic             wr_phase;
    logic             rd_phase;
    logic             reg_wr;
    logic [CA_W-1:0]  ca_word;

    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            len_q <= '0;
        end else if (start) begin
            cmd_q.write  <= req_write;
            cmd_q.regsp  <= req_reg;
            cmd_q.linear <= req_linear;
            cmd_q.addr   <= req_addr;
            len_q        <= (req_write && req_reg) ? REG_LEN : req_len;
        end
    end

    assign reg_wr  = cmd_q.write && cmd_q.regsp;
    assign ca_word = hb_make_ca(cmd_q);

    hbus_fsm #(
        .LAT_CYC (LAT_CYC),
        .GAP_CYC (GAP_CYC),
        .LEN_W   (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_write  (cmd_q.write),
        .skip_lat  (reg_wr),
        .len       (len_q),
        .rd_step   (rd_step),
        .state     (state),
        .ca_idx    (ca_idx),
        .first_gap (first_gap)
    );

    assign in_frame = (state == ST_CA) || (state == ST_LAT) || (state == ST_DATA);
    assign wr_phase = (state == ST_DATA) && cmd_q.write;
    assign rd_phase = (state == ST_DATA) && !cmd_q.write;

    hbus_ckgen u_ck (
        .clk  (clk),
        .rst  (rst),
        .run  (in_frame),
        .ck_o (ck_o)
    );

    hbus_rd_capture u_rd (
        .clk      (clk),
        .rst      (rst),
        .arm      (rd_phase),
        .rwds_i   (rwds_i),
        .dq_i     (dq_i),
        .byte_ok  (rd_step),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always_comb begin
        cs_n    = !in_frame;
        dq_oe   = 1'b0;
        dq_o    = 8'h00;
        rwds_oe = 1'b0;
        rwds_o  = 1'b0;
        wr_take = 1'b0;
        if (state == ST_CA) begin
            dq_oe = 1'b1;
            dq_o  = hb_ca_byte(ca_word, ca_idx);
        end else if (wr_phase) begin
            dq_oe   = 1'b1;
            dq_o    = wr_data;
            wr_take = 1'b1;
            if (!cmd_q.regsp) begin
                rwds_oe = 1'b1;
                rwds_o  = wr_mask;
            end
        end
    end

    assign done_o = first_gap;

endmodule

// File: rtl/hbus_ctrl_chk.sv
module hbus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic ck_o,
    input logic dq_oe,
    input logic rwds_oe,
    input logic wr_take,
    input logic rd_valid,
    input logic rwds_i,
    input logic done_o,
    input logic req_ready
);

    // R8 / R1: outside a frame nothing is driven and the clock rests low
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!dq_oe && !rwds_oe && !ck_o));

    // R3: clock inverts every cycle inside a frame
    a_r3_ck_toggles: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> (ck_o != $past(ck_o)));

    // R5 / R6: mask is only driven alongside write data
    a_r5_mask_with_data: assert property (@(posedge clk) disable iff (rst)
        rwds_oe |-> (dq_oe && wr_take));

    // R5: write bytes are consumed only inside a frame
    a_r5_take_in_frame: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> (!cs_n && dq_oe));

    // R7: every delivered read byte follows a strobe change
    a_r7_valid_after_edge: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(rwds_i) != $past(rwds_i, 2)));

    // R8: done marks the first cycle after a frame
    a_r8_done_after_frame: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cs_n && $past(!cs_n)));

    // R8: requests accepted only while idle
    a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cs_n);

endmodule

bind hbus_ctrl hbus_ctrl_chk u_chk (.*);

// File: tb/tb_hbus_ctrl.sv
`timescale 1ns/1ps
module tb_hbus_ctrl;

    localparam int LAT = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic       req_reg = 1'b0;
    logic       req_linear = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0] req_len = '0;
    logic [7:0] wr_data = '0;
    logic       wr_mask = 1'b0;
    logic       wr_take;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       done_o;
    logic       cs_n;
    logic       ck_o;
    logic [7:0] dq_o;
    logic       dq_oe;
    logic [7:0] dq_i = '0;
    logic       rwds_o;
    logic       rwds_oe;
    logic       rwds_i = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hbus_ctrl #(.LATENCY(LAT), .GAP_CYC(2), .LEN_W(8)) dut (.*);

    typedef struct packed {
        logic        wr;
        logic        rg;
        logic        lin;
        logic [31:0] addr;
        logic [7:0]  len;
        logic        rwds_ca;
        logic        stall;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{1'b1, 1'b0, 1'b1, 32'h0000_1235, 8'd4, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 32'h0040_0A0F, 8'd7, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b1, 32'h0000_0100, 8'd6, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 32'h00C0_3456, 8'd5, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 32'h0000_0001, 8'd9, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h0040_0001, 8'd9, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 32'h0040_0000, 8'd2, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b1, 32'hFFFF_FFF8, 8'd1, 1'b1, 1'b0}
    };

    function automatic logic [7:0] wpat(int j, int seed);
        return 8'(8'h3C + seed * 17 + j * 5);
    endfunction

    function automatic logic mpat(int j);
        return (j % 3) == 1;
    endfunction

    function automatic logic [7:0] rpat(int j, logic [7:0] base);
        return base ^ 8'(j * 29 + 7);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input vec_t v, input int seed);
        logic [47:0] ca;
        int ds, exp_len, k, sent, got, stalls;
        ca = {~v.wr, v.rg, v.lin, v.addr[31:3], 13'd0, v.addr[2:0]};
        ds = (v.wr && v.rg) ? 6 : 6 + 4 * LAT;
        exp_len = (v.wr && v.rg) ? 2 : int'(v.len);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = v.wr;
        req_reg    = v.rg;
        req_linear = v.lin;
        req_addr   = v.addr;
        req_len    = v.len;
        rwds_i     = v.rwds_ca;
        wr_data    = wpat(0, seed);
        wr_mask    = mpat(0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!cs_n, "R2 cs_n falls after accept", 32'(cs_n), 32'd0);
        k = 0; sent = 0; got = 0; stalls = 0;
        while (!cs_n && k < 2000) begin
            chk(ck_o == k[0], "R3 bus clock level", 32'(ck_o), 32'(k[0]));
            if (k < 6) begin
                chk(dq_oe && dq_o == ca[8*(5-k) +: 8], "R2 command byte", 32'(dq_o), 32'(ca[8*(5-k) +: 8]));
                if (k == 1) chk(dq_o[3] == v.addr[22], "R9 die select bit 35", 32'(dq_o[3]), 32'(v.addr[22]));
                if (k == 5) rwds_i = 1'b0;
            end
            if (v.wr) begin
                if (k == ds - 1) chk(!wr_take, "R4 no data before latency end", 32'(wr_take), 32'd0);
                if (k >= ds) begin
                    chk(wr_take && dq_oe, "R4 write data phase start", 32'(wr_take), 32'd1);
                    chk(dq_o == wpat(k - ds, seed), "R5 write byte", 32'(dq_o), 32'(wpat(k - ds, seed)));
                    if (v.rg)
                        chk(!rwds_oe, "R6 register write leaves strobe undriven", 32'(rwds_oe), 32'd0);
                    else
                        chk(rwds_oe && rwds_o == mpat(k - ds), "R5 write mask", 32'(rwds_o), 32'(mpat(k - ds)));
                    wr_data = wpat(k - ds + 1, seed);
                    wr_mask = mpat(k - ds + 1);
                end
            end else begin
                if (k == ds - 1) chk(!dq_oe && !rwds_oe, "R4 bus released for read", 32'(dq_oe), 32'd0);
                if (rd_valid) begin
                    chk(rd_data == rpat(got, v.addr[7:0]), "R7 read byte order", 32'(rd_data), 32'(rpat(got, v.addr[7:0])));
                    got++;
                end
                if (k >= ds && sent < int'(v.len)) begin
                    if (v.stall && (k % 3 == 0)) begin
                        stalls++;
                    end else begin
                        dq_i   = rpat(sent, v.addr[7:0]);
                        rwds_i = ~rwds_i;
                        sent++;
                    end
                end
            end
            k++;
            @(negedge clk);
        end
        chk(k == ds + exp_len + stalls, "R4 R7 frame length", 32'(k), 32'(ds + exp_len + stalls));
        chk(done_o, "R8 done in first idle cycle", 32'(done_o), 32'd1);
        chk(!dq_oe && !rwds_oe && !ck_o && !req_ready, "R8 released bus", {dq_oe, rwds_oe, ck_o, req_ready}, 32'd0);
        if (!v.wr) begin
            if (rd_valid) begin
                chk(rd_data == rpat(got, v.addr[7:0]), "R7 last read byte", 32'(rd_data), 32'(rpat(got, v.addr[7:0])));
                got++;
            end
            chk(got == int'(v.len), "R7 read byte count", 32'(got), 32'(v.len));
        end
        @(negedge clk);
        chk(cs_n && !req_ready && !done_o, "R8 second gap cycle", {cs_n, req_ready, done_o}, 32'd4);
        @(negedge clk);
        chk(req_ready && cs_n, "R8 ready after gap", 32'(req_ready), 32'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !ck_o && !dq_oe && !rwds_oe && req_ready, "R1 reset state",
            {cs_n, ck_o, dq_oe, rwds_oe, req_ready}, 32'h11);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && req_ready && !done_o, "R1 idle after reset", {cs_n, req_ready, done_o}, 32'd6);

        for (int i = 0; i < 8; i++) run_txn(VEC[i], i);

        // R1: reset in the middle of a read abandons the frame
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_reg = 1'b0;
        req_addr = 32'h0000_0020; req_len = 8'd4;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(!cs_n, "R2 frame open before reset", 32'(cs_n), 32'd0);
        rst = 1'b1;
        @(negedge clk);
        chk(cs_n && !ck_o && !dq_oe && req_ready, "R1 reset aborts frame", {cs_n, ck_o, dq_oe, req_ready}, 32'h9);
        rst = 1'b0;
        @(negedge clk);

        // R4: strobe high through the command phase of a short write
        run_txn('{1'b1, 1'b0, 1'b0, 32'h0000_0077, 8'd3, 1'b1, 1'b0}, 11);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule